// File: doc/BRIEF.md
# Coroutine Yield Control Unit

This block owns the program counter and the continuation pointer of a small stack machine. Instructions are 16 bits wide: an opcode byte, then an operand byte. The decoder outside the block supplies a control-flow kind for each instruction, a flag that tells whether a 32-bit immediate follows, and the current top of the operand stack (X). On every step strobe the block computes the next program counter and continuation pointer.

The machine has no branches and no flags. Every transfer of control is one exchange. The program counter takes the continuation pointer, and the continuation pointer takes the address of the next instruction. The same exchange serves as a call and as a return. A separate exchange operation loads the continuation pointer from X and hands the old value back, so software can save it or replace it.

The block also asks the operand stack to pop for the conditional yields. It latches a halt state that freezes everything until reset.

Top module: `yield_ctl`

## Requirements
- R1: While reset is active, and after reset, before any step, `pc_o` and `cp_o` read 0 and `halted_o` reads 0.
- R2: A step with kind 1 (sequential) and `imm32_i` low adds 2 to `pc_o` and leaves `cp_o` unchanged. Kinds 6 and 7 behave exactly like kind 1.
- R3: A non-yield step (kinds 1, 5, 6, 7) with `imm32_i` high adds 6 to `pc_o`, skipping the instruction and its immediate.
- R4: A step with kind 2 (unconditional yield) loads `pc_o` with the old `cp_o` and loads `cp_o` with the old `pc_o` plus 2, whatever `imm32_i` is. `pop_o` stays low.
- R5: A step with kind 3 yields as in R4 when `x_i` is zero, and otherwise adds 2 to `pc_o`. `pop_o` is high during that step in both cases.
- R6: A step with kind 4 yields as in R4 when bit 31 of `x_i` is set, and otherwise adds 2 to `pc_o`. `pop_o` is high during that step in both cases.
- R7: A step with kind 5 (exchange) loads `cp_o` from `x_i` and advances `pc_o` as in R2 or R3. During that step `cp_old_o` presents the continuation pointer value from before the step.
- R8: A step with kind 0 (halt) sets `halted_o` and leaves `pc_o` and `cp_o` unchanged. While halted, steps have no effect on `pc_o` or `cp_o`, `pop_o` stays low, and `halted_o` stays high until reset.
- R9: With `step_i` low, `pc_o`, `cp_o` and `halted_o` keep their values and `pop_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_i | input | 1 | Executes one instruction on this edge |
| cf_kind_i | input | 3 | Control-flow kind: 0 halt, 1 sequential, 2 yield, 3 yield if zero, 4 yield if negative, 5 exchange with CP, 6 and 7 sequential |
| imm32_i | input | 1 | A 32-bit immediate follows the instruction |
| x_i | input | DATA_W | Top of the operand stack |
| pc_o | output | ADDR_W | Program counter |
| cp_o | output | ADDR_W | Continuation pointer |
| pop_o | output | 1 | Pop request to the operand stack for this step |
| halted_o | output | 1 | Halt state |
| cp_old_o | output | ADDR_W | Current continuation pointer, for exchange into X |

## Verification
The bench builds the block with its defaults: 32-bit addresses and X, 2-byte instructions and 4-byte immediates. With this build the sign test falls on bit 31, so the values 0x7FFFFFFF, 0x80000000 and all-ones probe both sides of the negative condition. The 6-byte skip can be seen against the 2-byte step, including an exchange and a yield that carry the immediate flag. Chained yields and exchanges show that the continuation address is saved and restored across coroutine switches.

// File: rtl/yc_pkg.sv
package yc_pkg;
  typedef enum logic [2:0] {
    CF_HALT    = 3'd0,
    CF_SEQ     = 3'd1,
    CF_YIELD   = 3'd2,
    CF_YIELD_Z = 3'd3,
    CF_YIELD_N = 3'd4,
    CF_SWAP    = 3'd5
  } cf_kind_e;
endpackage

// File: rtl/yc_cond.sv
module yc_cond
  import yc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        kind_i,
  input  logic [DATA_W-1:0] x_i,
  output logic              is_cond_o,
  output logic              taken_o
);
  logic x_zero, x_neg;

  always_comb begin
    x_zero    = (x_i == '0);
    x_neg     = x_i[DATA_W-1];
    is_cond_o = (kind_i == CF_YIELD_Z) || (kind_i == CF_YIELD_N);
    case (kind_i)
      CF_YIELD:   taken_o = 1'b1;
      CF_YIELD_Z: taken_o = x_zero;
      CF_YIELD_N: taken_o = x_neg;
      default:    taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/yc_next.sv
module yc_next
  import yc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int INSN_BYTES = 2,
  parameter int IMM_BYTES  = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] cp_i,
  input  logic [2:0]        kind_i,
  input  logic              imm32_i,
  input  logic              taken_i,
  input  logic [DATA_W-1:0] x_i,
  output logic [ADDR_W-1:0] pc_nxt_o,
  output logic [ADDR_W-1:0] cp_nxt_o,
  output logic              halt_set_o
);
  localparam logic [ADDR_W-1:0] STEP_SHORT = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] STEP_LONG  = ADDR_W'(INSN_BYTES + IMM_BYTES);

  logic [ADDR_W-1:0] pc_short, pc_seq;

  always_comb begin
    pc_short   = pc_i + STEP_SHORT;
    pc_seq     = imm32_i ? (pc_i + STEP_LONG) : pc_short;
    pc_nxt_o   = pc_seq;
    cp_nxt_o   = cp_i;
    halt_set_o = 1'b0;
    case (kind_i)
      CF_HALT: begin
        pc_nxt_o   = pc_i;
        halt_set_o = 1'b1;
      end
      CF_YIELD, CF_YIELD_Z, CF_YIELD_N: begin
        if (taken_i) begin
          pc_nxt_o = cp_i;
          cp_nxt_o = pc_short;
        end else begin
          pc_nxt_o = pc_short;
        end
      end
      CF_SWAP: cp_nxt_o = x_i[ADDR_W-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/yield_ctl.sv
module yield_ctl
  import yc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int INSN_BYTES  = 2,
  parameter int IMM_BYTES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [2:0]        cf_kind_i,
  input  logic              imm32_i,
  input  logic [DATA_W-1:0] x_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] cp_o,
  output logic              pop_o,
  output logic              halted_o,
  output logic [ADDR_W-1:0] cp_old_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_q_n;
  logic [ADDR_W-1:0]      pc_q, cp_q, pc_nxt, cp_nxt;
  logic                   halt_q, halt_set, is_cond, taken, adv_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[SYNC_STAGES-1];

  yc_cond #(.DATA_W(DATA_W)) u_cond (
    .kind_i    (cf_kind_i),
    .x_i       (x_i),
    .is_cond_o (is_cond),
    .taken_o   (taken)
  );

  yc_next #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .INSN_BYTES(INSN_BYTES), .IMM_BYTES(IMM_BYTES)
  ) u_next (
    .pc_i       (pc_q),
    .cp_i       (cp_q),
    .kind_i     (cf_kind_i),
    .imm32_i    (imm32_i),
    .taken_i    (taken),
    .x_i        (x_i),
    .pc_nxt_o   (pc_nxt),
    .cp_nxt_o   (cp_nxt),
    .halt_set_o (halt_set)
  );

  always_comb adv_en = step_i && !halt_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pc_q   <= '0;
      cp_q   <= '0;
      halt_q <= 1'b0;
    end else if (adv_en) begin
      pc_q   <= pc_nxt;
      cp_q   <= cp_nxt;
      halt_q <= halt_set;
    end
  end

  assign pc_o     = pc_q;
  assign cp_o     = cp_q;
  assign cp_old_o = cp_q;
  assign halted_o = halt_q;
  assign pop_o    = adv_en && is_cond;
endmodule

// File: rtl/yield_ctl_chk.sv
module yield_ctl_chk #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 2
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              step_i,
  input logic [2:0]        cf_kind_i,
  input logic              imm32_i,
  input logic [ADDR_W-1:0] x_lo,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] cp_o,
  input logic              pop_o,
  input logic              halted_o
);
  localparam logic [ADDR_W-1:0] STEP_SHORT = ADDR_W'(INSN_BYTES);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !step_i |=> ($stable(pc_o) && $stable(cp_o) && $stable(halted_o)));

  // R4
  yield_swap_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_i && !halted_o && cf_kind_i == 3'd2) |=>
      (pc_o == $past(cp_o) && cp_o == $past(pc_o) + STEP_SHORT));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_i && !halted_o && cf_kind_i == 3'd1 && !imm32_i) |=>
      (pc_o == $past(pc_o) + STEP_SHORT && $stable(cp_o)));

  // R7
  swap_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_i && !halted_o && cf_kind_i == 3'd5) |=> (cp_o == $past(x_lo)));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    halted_o |=> (halted_o && $stable(pc_o) && $stable(cp_o)));

  // R5 R6
  pop_cause_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    pop_o |-> (step_i && !halted_o && (cf_kind_i == 3'd3 || cf_kind_i == 3'd4)));
endmodule

bind yield_ctl yield_ctl_chk #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .step_i    (step_i),
  .cf_kind_i (cf_kind_i),
  .imm32_i   (imm32_i),
  .x_lo      (x_i[ADDR_W-1:0]),
  .pc_o      (pc_o),
  .cp_o      (cp_o),
  .pop_o     (pop_o),
  .halted_o  (halted_o)
);

// File: tb/yield_ctl_bench.sv
`timescale 1ns/1ps
module yield_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i;
  logic [2:0]  cf_kind_i;
  logic        imm32_i;
  logic [31:0] x_i;
  logic [31:0] pc_o, cp_o, cp_old_o;
  logic        pop_o, halted_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  yield_ctl u_yield_ctl (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .cf_kind_i(cf_kind_i),
    .imm32_i(imm32_i), .x_i(x_i), .pc_o(pc_o), .cp_o(cp_o),
    .pop_o(pop_o), .halted_o(halted_o), .cp_old_o(cp_old_o)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic        imm;
    logic [31:0] x;
    logic [31:0] pc;
    logic [31:0] cp;
    logic        pop;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b0, 32'h0,        32'h2,   32'h0,   1'b0},  // R2
    '{3'd1, 1'b1, 32'h0,        32'h8,   32'h0,   1'b0},  // R3
    '{3'd5, 1'b0, 32'h100,      32'hA,   32'h100, 1'b0},  // R7
    '{3'd2, 1'b0, 32'h0,        32'h100, 32'hC,   1'b0},  // R4
    '{3'd1, 1'b0, 32'h0,        32'h102, 32'hC,   1'b0},  // R2
    '{3'd3, 1'b0, 32'h5,        32'h104, 32'hC,   1'b1},  // R5 not taken
    '{3'd3, 1'b0, 32'h0,        32'hC,   32'h106, 1'b1},  // R5 taken
    '{3'd4, 1'b0, 32'h7FFFFFFF, 32'hE,   32'h106, 1'b1},  // R6 not taken
    '{3'd4, 1'b0, 32'h80000000, 32'h106, 32'h10,  1'b1},  // R6 taken
    '{3'd6, 1'b0, 32'h0,        32'h108, 32'h10,  1'b0},  // R2 kind 6
    '{3'd7, 1'b1, 32'h0,        32'h10E, 32'h10,  1'b0},  // R3 kind 7
    '{3'd5, 1'b1, 32'h200,      32'h114, 32'h200, 1'b0},  // R7 with imm
    '{3'd2, 1'b1, 32'h0,        32'h200, 32'h116, 1'b0},  // R4 imm ignored
    '{3'd4, 1'b0, 32'hFFFFFFFF, 32'h116, 32'h202, 1'b1}   // R6 all ones
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [2:0] k, input logic im,
                       input logic [31:0] x);
    step_i = s; cf_kind_i = k; imm32_i = im; x_i = x;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b0, 3'd1, 1'b0, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] prev_cp;
    logic [31:0] hpc, hcp;
    do_reset();
    chk(pc_o == 0, "R1 pc", pc_o, 0);
    chk(cp_o == 0, "R1 cp", cp_o, 0);
    chk(halted_o == 0, "R1 halted", {31'b0, halted_o}, 0);

    prev_cp = 32'h0;
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].kind, VECS[i].imm, VECS[i].x);
      #0.5;
      chk(pop_o == VECS[i].pop, $sformatf("R5/R6 pop vec%0d", i),
          {31'b0, pop_o}, {31'b0, VECS[i].pop});
      if (VECS[i].kind == 3'd5)
        chk(cp_old_o == prev_cp, $sformatf("R7 cp_old vec%0d", i), cp_old_o, prev_cp);
      @(negedge clk);
      chk(pc_o == VECS[i].pc, $sformatf("pc vec%0d", i), pc_o, VECS[i].pc);
      chk(cp_o == VECS[i].cp, $sformatf("cp vec%0d", i), cp_o, VECS[i].cp);
      prev_cp = VECS[i].cp;
    end

    // R9: no step, yield kind presented
    drive(1'b0, 3'd2, 1'b0, 32'h0);
    #0.5;
    chk(pop_o == 0, "R9 pop", {31'b0, pop_o}, 0);
    repeat (2) @(negedge clk);
    chk(pc_o == 32'h116, "R9 pc", pc_o, 32'h116);
    chk(cp_o == 32'h202, "R9 cp", cp_o, 32'h202);

    // R8: halt
    hpc = pc_o; hcp = cp_o;
    drive(1'b1, 3'd0, 1'b0, 32'h0);
    @(negedge clk);
    chk(halted_o == 1, "R8 halted", {31'b0, halted_o}, 1);
    chk(pc_o == hpc, "R8 pc at halt", pc_o, hpc);
    drive(1'b1, 3'd2, 1'b0, 32'h0);
    @(negedge clk);
    chk(pc_o == hpc, "R8 pc frozen", pc_o, hpc);
    chk(cp_o == hcp, "R8 cp frozen", cp_o, hcp);
    drive(1'b1, 3'd3, 1'b0, 32'h0);
    #0.5;
    chk(pop_o == 0, "R8 pop", {31'b0, pop_o}, 0);
    @(negedge clk);
    drive(1'b1, 3'd5, 1'b1, 32'h1234);
    @(negedge clk);
    chk(cp_o == hcp, "R8 cp after swap", cp_o, hcp);
    chk(halted_o == 1, "R8 still halted", {31'b0, halted_o}, 1);

    // R1: reset clears halt
    do_reset();
    chk(pc_o == 0, "R1 pc after halt", pc_o, 0);
    chk(cp_o == 0, "R1 cp after halt", cp_o, 0);
    chk(halted_o == 0, "R1 halt cleared", {31'b0, halted_o}, 0);
    drive(1'b1, 3'd1, 1'b0, 32'h0);
    @(negedge clk);
    chk(pc_o == 2, "R2 step after reset", pc_o, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule